// File: doc/BRIEF.md
# SPI Port with Receive Word Match

This block is a synchronous serial port that runs either as the bus master or as a selected slave. It moves one word each frame in both directions at once, on a serial clock, a master-out line, a master-in line and an active-low select line. All four combinations of clock idle level and capture edge are available. Bit order can be set to most-significant first or least-significant first, and the frame length can be 8 or 16 bits. In master mode the serial clock comes from the system clock through a programmable half-period divider.

Software writes one word into a transmit holding register and reads one word from a receive holding register. Each holding register sits in front of a shift register, so the next transmit word can be queued while the current word is on the wire. When a frame ends, the received word is compared with a programmed match value, and a sticky flag is set if they are equal. A master that sees its select input pulled low by another device records a mode fault. It then stops driving the bus until software clears the fault. A word that finishes while the previous one is still unread is dropped, and an overrun flag is set. The pins are given as separate data-out, output-enable and data-in signals, so the pad ring can build the tri-state buffers.

Top module: `spiMatchPort`

## Requirements
- R1: In master mode the serial clock rests at `cfgCpol` whenever select is high. Each half period lasts `cfgDiv`+1 system clocks. Select goes low at the start of the frame and returns high `cfgDiv`+1 clocks after the last serial clock edge.
- R2: With `cfgCpha`=0, bits are captured on the first (leading) edge of each clock pulse. With `cfgCpha`=1, they are captured on the second (trailing) edge. The master samples `misoIn` on its own capture edges.
- R3: With `cfgLsbFirst`=1, bit 0 of the word goes out first and the first received bit lands in bit 0. With `cfgLsbFirst`=0, the top bit of the frame goes first in both directions.
- R4: With `cfgWide`=1 a frame has 16 bits. With `cfgWide`=0 it has 8 bits, the word occupies bits 7:0 of `txData` and `rxData`, `txData[15:8]` has no effect, and `rxData[15:8]` reads zero.
- R5: `txEmpty` returns to 1 as soon as the queued word has moved into the shift register, so a second word can be written during the frame. A write while `txEmpty` is 0 is ignored.
- R6: `rxFull` is set when a frame ends and is cleared by a one-cycle `rxRead` pulse.
- R7: If a frame ends while `rxFull` is 1 and no read occurs in that cycle, `overrun` is set and `rxData` keeps the older word. `clrOverrun` clears the flag.
- R8: `matchFlag` is set at the end of any frame whose received word, masked to the frame length, equals `matchValue` under the same mask. It stays set until `clrMatch`, and no other event sets it.
- R9: In master mode, a low level on `ssIn` sets `modeFault` and `irq`, aborts any frame in progress, drops `sclkOe`, `mosiOe` and `ssOe`, and holds off any queued word.
- R10: `modeFault` stays set after `ssIn` returns high, until `clrModeFault` is pulsed. After that the master drives the bus again and sends the queued word.
- R11: In slave mode the block loads its queued word when `ssIn` falls and shifts it out on `misoOut`. `misoOe` is high only while it is selected. It assembles the word from `mosiIn` using the same phase, order and length settings.
- R12: `irq` is the OR of `modeFault`, `overrun` and `matchFlag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgEnable | input | 1 | Port enable |
| cfgMaster | input | 1 | 1 = master, 0 = slave |
| cfgCpol | input | 1 | Serial clock idle level |
| cfgCpha | input | 1 | 0 = capture on leading edge, 1 = on trailing edge |
| cfgLsbFirst | input | 1 | 1 = least significant bit first |
| cfgWide | input | 1 | 1 = 16-bit frames, 0 = 8-bit frames |
| cfgDiv | input | 8 | Master half period minus one, in system clocks |
| matchValue | input | 16 | Value compared against each received word |
| txWrite | input | 1 | Write strobe for the transmit holding register |
| txData | input | 16 | Transmit word |
| rxRead | input | 1 | Read strobe, empties the receive holding register |
| rxData | output | 16 | Receive holding register |
| clrModeFault | input | 1 | Clears the mode-fault flag |
| clrOverrun | input | 1 | Clears the overrun flag |
| clrMatch | input | 1 | Clears the match flag |
| txEmpty | output | 1 | Transmit holding register can take a word |
| rxFull | output | 1 | Receive holding register holds an unread word |
| modeFault | output | 1 | Another master pulled select low |
| overrun | output | 1 | A received word was lost |
| matchFlag | output | 1 | A received word equalled the match value |
| irq | output | 1 | Interrupt request |
| sclkOut | output | 1 | Serial clock driven as master |
| sclkOe | output | 1 | Serial clock output enable |
| sclkIn | input | 1 | Serial clock received as slave |
| mosiOut | output | 1 | Master-out data |
| mosiOe | output | 1 | Master-out enable |
| mosiIn | input | 1 | Master-out data received as slave |
| misoOut | output | 1 | Slave-out data |
| misoOe | output | 1 | Slave-out enable |
| misoIn | input | 1 | Master-in data received as master |
| ssOut | output | 1 | Select driven as master, active low |
| ssOe | output | 1 | Select output enable |
| ssIn | input | 1 | Select input, active low |

## Verification
The hardest states to reach are the ones that need two events to overlap. An overrun needs a second frame to finish while the first word is still unread. A rejected write needs the transmit register to be full while nothing moves it out, which the master normally does within a cycle. The bench reaches the first by queueing a second word as soon as `txEmpty` returns high and then not reading. It reaches the second by raising a mode fault, which freezes the queued word so a later write can be shown to change nothing. Master frames use an inverting loopback from `mosiOut` to `misoIn`. This keeps received and sent words distinct, and every bit sent on the wire is also recorded on the bench's own capture edges.

// File: rtl/spiMatchPkg.sv
package spiMatchPkg;
  // strobes from the sequencer to the datapath, one cycle each
  typedef struct packed {
    logic load;    // move queued word into the shift register
    logic shift;   // present the next outgoing bit
    logic sample;  // capture one incoming bit
    logic done;    // frame complete, hand over received word
    logic abort;   // frame dropped before completion
  } spiStrobeT;
endpackage

// File: rtl/spiMatchCtrl.sv
module spiMatchCtrl
  import spiMatchPkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8,
  parameter int DIV_W    = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgEnable,
  input  logic             cfgMaster,
  input  logic             cfgCpol,
  input  logic             cfgCpha,
  input  logic             cfgWide,
  input  logic [DIV_W-1:0] cfgDiv,
  input  logic             txFull,
  input  logic             clrModeFault,
  input  logic             sclkIn,
  input  logic             ssIn,
  output spiStrobeT        strb,
  output logic             sclkOut,
  output logic             ssOut,
  output logic             modeFault,
  output logic             masterOn,
  output logic             slaveSel
);
  localparam int CNT_W = $clog2(2 * DATA_W + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_HOLD} stateT;

  stateT            state;
  logic [CNT_W-1:0] edgeCnt;
  logic [CNT_W-1:0] totalEdges;
  logic [CNT_W-1:0] lastEdge;
  logic [DIV_W-1:0] halfCnt;
  logic [1:0]       sclkSync;
  logic [1:0]       ssSync;
  logic             sclkLast;
  logic             ssLow;
  logic             tick;
  logic             edgeStb;
  logic             faultSet;
  logic             slaveOn;
  logic             slaveEdge;

  assign totalEdges = cfgWide ? CNT_W'(2 * DATA_W) : CNT_W'(2 * NARROW_W);
  assign lastEdge   = totalEdges - CNT_W'(1);
  assign ssLow      = ~ssSync[1];
  assign faultSet   = cfgEnable & cfgMaster & ssLow;
  assign masterOn   = cfgEnable & cfgMaster & ~modeFault;
  assign slaveOn    = cfgEnable & ~cfgMaster;
  assign tick       = (halfCnt == cfgDiv);
  assign slaveEdge  = sclkSync[1] ^ sclkLast;
  assign slaveSel   = slaveOn & ssLow & (state != ST_IDLE);
  assign edgeStb    = (state == ST_RUN) && (edgeCnt != totalEdges) &&
                      (cfgMaster ? tick : slaveEdge);

  always_comb begin
    strb       = '0;
    strb.load  = (state == ST_IDLE) &&
                 (cfgMaster ? (masterOn & txFull & ~faultSet) : (slaveOn & ssLow));
    strb.abort = (state != ST_IDLE) &&
                 (cfgMaster ? (faultSet | ~cfgEnable) : (~slaveOn | ~ssLow));
    strb.done  = (state == ST_RUN) && !strb.abort && (edgeCnt == totalEdges) &&
                 (cfgMaster ? tick : 1'b1);
    strb.sample = edgeStb && !strb.abort &&
                  (cfgCpha ? edgeCnt[0] : ~edgeCnt[0]);
    strb.shift  = edgeStb && !strb.abort &&
                  (cfgCpha ? (~edgeCnt[0] && edgeCnt != '0)
                           : (edgeCnt[0] && edgeCnt != lastEdge));
  end

  // input synchronisers for the slave-side pins and the select input
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSync <= '0;
      ssSync   <= '1;
      sclkLast <= 1'b0;
    end else begin
      sclkSync <= {sclkSync[0], sclkIn};
      ssSync   <= {ssSync[0], ssIn};
      sclkLast <= sclkSync[1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeFault <= 1'b0;
    end else if (faultSet) begin
      modeFault <= 1'b1;
    end else if (clrModeFault) begin
      modeFault <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      edgeCnt <= '0;
      halfCnt <= '0;
      ssOut   <= 1'b1;
      sclkOut <= 1'b0;
    end else if (strb.abort) begin
      state   <= ST_IDLE;
      ssOut   <= 1'b1;
      sclkOut <= cfgCpol;
    end else begin
      case (state)
        ST_IDLE: begin
          edgeCnt <= '0;
          halfCnt <= '0;
          sclkOut <= cfgCpol;
          ssOut   <= 1'b1;
          if (strb.load) begin
            state <= ST_RUN;
            ssOut <= ~cfgMaster;
          end
        end
        ST_RUN: begin
          if (cfgMaster) begin
            halfCnt <= tick ? '0 : halfCnt + DIV_W'(1);
            if (edgeStb) sclkOut <= ~sclkOut;
          end else begin
            sclkOut <= cfgCpol;
          end
          if (edgeStb) edgeCnt <= edgeCnt + CNT_W'(1);
          if (strb.done) begin
            state   <= cfgMaster ? ST_IDLE : ST_HOLD;
            ssOut   <= 1'b1;
            sclkOut <= cfgCpol;
          end
        end
        default: begin
          sclkOut <= cfgCpol;
        end
      endcase
    end
  end

  AST_SCLK_QUIET_UNSELECTED: assert property (@(posedge clk) disable iff (!rstN)
    (ssOut && $past(ssOut)) |-> (sclkOut == $past(cfgCpol))); // R1
  AST_FAULT_RELEASES_SS: assert property (@(posedge clk) disable iff (!rstN)
    modeFault |-> ssOut); // R9
  AST_EDGE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) |-> (edgeCnt <= totalEdges)); // R4
endmodule

// File: rtl/spiMatchData.sv
module spiMatchData
  import spiMatchPkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  spiStrobeT         strb,
  input  logic              cfgMaster,
  input  logic              cfgLsbFirst,
  input  logic              cfgWide,
  input  logic              txWrite,
  input  logic [DATA_W-1:0] txData,
  input  logic              rxRead,
  input  logic [DATA_W-1:0] matchValue,
  input  logic              clrOverrun,
  input  logic              clrMatch,
  input  logic              misoIn,
  input  logic              mosiIn,
  output logic              txBit,
  output logic              txFull,
  output logic              rxFull,
  output logic [DATA_W-1:0] rxHold,
  output logic              overrun,
  output logic              matchFlag
);
  localparam int PAD_W = DATA_W - NARROW_W;

  logic [DATA_W-1:0] txHold;
  logic [DATA_W-1:0] txSh;
  logic [DATA_W-1:0] rxSh;
  logic [DATA_W-1:0] rxWord;
  logic [DATA_W-1:0] lenMask;
  logic [1:0]        mosiSync;
  logic              rxIn;
  logic              rxTake;
  logic              lost;

  assign lenMask = cfgWide ? '1 : {{PAD_W{1'b0}}, {NARROW_W{1'b1}}};
  assign txBit   = cfgLsbFirst ? txSh[0]
                 : (cfgWide ? txSh[DATA_W-1] : txSh[NARROW_W-1]);
  assign rxIn    = cfgMaster ? misoIn : mosiSync[1];

  // an LSB-first narrow frame collects in the upper half of the shifter
  always_comb begin
    if (cfgWide)          rxWord = rxSh;
    else if (cfgLsbFirst) rxWord = {{PAD_W{1'b0}}, rxSh[DATA_W-1:PAD_W]};
    else                  rxWord = {{PAD_W{1'b0}}, rxSh[NARROW_W-1:0]};
  end

  assign rxTake = strb.done && (!rxFull || rxRead);
  assign lost   = strb.done && rxFull && !rxRead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) mosiSync <= '0;
    else       mosiSync <= {mosiSync[0], mosiIn};
  end

  // transmit side: holding register in front of the shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txHold <= '0;
      txFull <= 1'b0;
      txSh   <= '0;
    end else begin
      if (strb.load) begin
        txSh   <= txFull ? txHold : '0;
        txFull <= 1'b0;
      end else begin
        if (txWrite && !txFull) begin
          txHold <= txData;
          txFull <= 1'b1;
        end
        if (strb.shift) begin
          txSh <= cfgLsbFirst ? (txSh >> 1) : (txSh << 1);
        end
      end
    end
  end

  // receive side: shifter, holding register and flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSh      <= '0;
      rxHold    <= '0;
      rxFull    <= 1'b0;
      overrun   <= 1'b0;
      matchFlag <= 1'b0;
    end else begin
      if (strb.load || strb.abort) begin
        rxSh <= '0;
      end else if (strb.sample) begin
        rxSh <= cfgLsbFirst ? {rxIn, rxSh[DATA_W-1:1]} : {rxSh[DATA_W-2:0], rxIn};
      end
      if (rxTake) rxHold <= rxWord;
      rxFull <= (rxFull && !rxRead) || strb.done;
      if (lost)            overrun <= 1'b1;
      else if (clrOverrun) overrun <= 1'b0;
      if (strb.done && (rxWord == (matchValue & lenMask))) matchFlag <= 1'b1;
      else if (clrMatch)                                    matchFlag <= 1'b0;
    end
  end

  AST_TX_EMPTY_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> !txFull); // R5
  AST_RX_KEPT_WHEN_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (rxFull && !rxRead) |=> (rxHold == $past(rxHold))); // R7
  AST_OVERRUN_ON_LOSS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.done && rxFull && !rxRead) |=> overrun); // R7
  AST_MATCH_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.done && !matchFlag) |=> !matchFlag); // R8
endmodule

// File: rtl/spiMatchPort.sv
module spiMatchPort
  import spiMatchPkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8,
  parameter int DIV_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgEnable,
  input  logic              cfgMaster,
  input  logic              cfgCpol,
  input  logic              cfgCpha,
  input  logic              cfgLsbFirst,
  input  logic              cfgWide,
  input  logic [DIV_W-1:0]  cfgDiv,
  input  logic [DATA_W-1:0] matchValue,
  input  logic              txWrite,
  input  logic [DATA_W-1:0] txData,
  input  logic              rxRead,
  output logic [DATA_W-1:0] rxData,
  input  logic              clrModeFault,
  input  logic              clrOverrun,
  input  logic              clrMatch,
  output logic              txEmpty,
  output logic              rxFull,
  output logic              modeFault,
  output logic              overrun,
  output logic              matchFlag,
  output logic              irq,
  output logic              sclkOut,
  output logic              sclkOe,
  input  logic              sclkIn,
  output logic              mosiOut,
  output logic              mosiOe,
  input  logic              mosiIn,
  output logic              misoOut,
  output logic              misoOe,
  input  logic              misoIn,
  output logic              ssOut,
  output logic              ssOe,
  input  logic              ssIn
);
  spiStrobeT strb;
  logic      txFull;
  logic      txBit;
  logic      masterOn;
  logic      slaveSel;

  spiMatchCtrl #(.DATA_W(DATA_W), .NARROW_W(NARROW_W), .DIV_W(DIV_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgMaster(cfgMaster),
    .cfgCpol(cfgCpol), .cfgCpha(cfgCpha), .cfgWide(cfgWide), .cfgDiv(cfgDiv),
    .txFull(txFull), .clrModeFault(clrModeFault), .sclkIn(sclkIn), .ssIn(ssIn),
    .strb(strb), .sclkOut(sclkOut), .ssOut(ssOut), .modeFault(modeFault),
    .masterOn(masterOn), .slaveSel(slaveSel)
  );

  spiMatchData #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgMaster(cfgMaster),
    .cfgLsbFirst(cfgLsbFirst), .cfgWide(cfgWide), .txWrite(txWrite),
    .txData(txData), .rxRead(rxRead), .matchValue(matchValue),
    .clrOverrun(clrOverrun), .clrMatch(clrMatch), .misoIn(misoIn),
    .mosiIn(mosiIn), .txBit(txBit), .txFull(txFull), .rxFull(rxFull),
    .rxHold(rxData), .overrun(overrun), .matchFlag(matchFlag)
  );

  assign txEmpty = ~txFull;
  assign irq     = modeFault | overrun | matchFlag;
  assign sclkOe  = masterOn;
  assign mosiOe  = masterOn;
  assign ssOe    = masterOn;
  assign mosiOut = txBit;
  assign misoOut = txBit;
  assign misoOe  = slaveSel;

  AST_FAULT_STOPS_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modeFault) |-> (!sclkOe && !mosiOe && !ssOe)); // R9
  AST_MISO_ONLY_AS_SLAVE: assert property (@(posedge clk) disable iff (!rstN)
    misoOe |-> (!cfgMaster && !mosiOe)); // R11
endmodule

// File: tb/sim_spiMatchPort.sv
module sim_spiMatchPort;
  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgEnable, cfgMaster, cfgCpol, cfgCpha, cfgLsbFirst, cfgWide;
  logic [7:0]  cfgDiv;
  logic [15:0] matchValue, txData, rxData;
  logic        txWrite, rxRead, clrModeFault, clrOverrun, clrMatch;
  logic        txEmpty, rxFull, modeFault, overrun, matchFlag, irq;
  logic        sclkOut, sclkOe, sclkIn, mosiOut, mosiOe, mosiIn;
  logic        misoOut, misoOe, misoIn, ssOut, ssOe, ssIn;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  // bench-side monitor of the master wire
  bit          capOn = 0;
  bit          tbCpol, tbCpha;
  logic [15:0] capBits;
  int          capCnt, lastEdgeCyc, halfMin, halfMax, ssRiseCyc;

  always #2 clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  // inverting loopback keeps the received word distinct from the sent one
  assign misoIn = ~mosiOut;

  spiMatchPort u0 (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgMaster(cfgMaster),
    .cfgCpol(cfgCpol), .cfgCpha(cfgCpha), .cfgLsbFirst(cfgLsbFirst),
    .cfgWide(cfgWide), .cfgDiv(cfgDiv), .matchValue(matchValue),
    .txWrite(txWrite), .txData(txData), .rxRead(rxRead), .rxData(rxData),
    .clrModeFault(clrModeFault), .clrOverrun(clrOverrun), .clrMatch(clrMatch),
    .txEmpty(txEmpty), .rxFull(rxFull), .modeFault(modeFault),
    .overrun(overrun), .matchFlag(matchFlag), .irq(irq),
    .sclkOut(sclkOut), .sclkOe(sclkOe), .sclkIn(sclkIn),
    .mosiOut(mosiOut), .mosiOe(mosiOe), .mosiIn(mosiIn),
    .misoOut(misoOut), .misoOe(misoOe), .misoIn(misoIn),
    .ssOut(ssOut), .ssOe(ssOe), .ssIn(ssIn)
  );

  always @(sclkOut) begin
    if (capOn) begin
      if (lastEdgeCyc >= 0) begin
        if (cyc - lastEdgeCyc < halfMin) halfMin = cyc - lastEdgeCyc;
        if (cyc - lastEdgeCyc > halfMax) halfMax = cyc - lastEdgeCyc;
      end
      lastEdgeCyc = cyc;
      if ((sclkOut != tbCpol) ^ tbCpha) begin
        capBits = {capBits[14:0], mosiOut};
        capCnt  = capCnt + 1;
      end
    end
  end

  always @(posedge ssOut) if (capOn) ssRiseCyc = cyc;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] serialOf(input logic [15:0] w, input bit lsb, input int n);
    logic [15:0] s = '0;
    for (int i = 0; i < n; i++) s[n-1-i] = lsb ? w[i] : w[n-1-i];
    return s;
  endfunction

  function automatic logic [15:0] maskOf(input bit wide);
    return wide ? 16'hFFFF : 16'h00FF;
  endfunction

  task automatic setCfg(input bit m, input bit pol, input bit pha, input bit lsb,
                        input bit wide, input logic [7:0] div);
    @(negedge clk);
    cfgMaster = m; cfgCpol = pol; cfgCpha = pha; cfgLsbFirst = lsb;
    cfgWide = wide; cfgDiv = div; cfgEnable = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic writeTx(input logic [15:0] w);
    @(negedge clk); txWrite = 1'b1; txData = w;
    @(negedge clk); txWrite = 1'b0;
  endtask

  task automatic pulseRead();
    @(negedge clk); rxRead = 1'b1;
    @(negedge clk); rxRead = 1'b0;
  endtask

  task automatic waitRx();
    for (int i = 0; i < 3000 && !rxFull; i++) @(negedge clk);
  endtask

  task automatic testReset();
    check("R6", "rxFull after reset", rxFull, 1'b0);
    check("R5", "txEmpty after reset", txEmpty, 1'b1);
    check("R12", "irq after reset", irq, 1'b0);
    check("R9", "modeFault after reset", modeFault, 1'b0);
    check("R11", "misoOe after reset", misoOe, 1'b0);
  endtask

  task automatic masterXfer(input logic [15:0] w, input bit pol, input bit pha,
                            input bit lsb, input bit wide, input logic [7:0] div);
    int n = wide ? 16 : 8;
    setCfg(1'b1, pol, pha, lsb, wide, div);
    check("R1", "sclk idle level", sclkOut, pol);
    check("R1", "ss idle high", ssOut, 1'b1);
    capBits = '0; capCnt = 0; lastEdgeCyc = -1; halfMin = 1000000; halfMax = 0;
    ssRiseCyc = -1; tbCpol = pol; tbCpha = pha; capOn = 1;
    writeTx(w);
    waitRx();
    repeat (2) @(negedge clk);
    capOn = 0;
    check("R1", "half period min", halfMin, div + 1);
    check("R1", "half period max", halfMax, div + 1);
    check("R1", "ss release delay", ssRiseCyc - lastEdgeCyc, div + 1);
    check("R4", "edges captured", capCnt, n);
    check("R3", "wire bit order", capBits & maskOf(wide), serialOf(w, lsb, n));
    check("R2", "received word", rxData, ~w & maskOf(wide));
    check("R6", "rxFull set", rxFull, 1'b1);
    pulseRead();
    check("R6", "rxFull cleared by read", rxFull, 1'b0);
  endtask

  task automatic testMatch();
    setCfg(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1);
    matchValue = 16'h00A5;
    writeTx(16'h005A);
    waitRx(); @(negedge clk);
    check("R8", "match on equal word", matchFlag, 1'b1);
    check("R12", "irq from match", irq, 1'b1);
    pulseRead();
    @(negedge clk); clrMatch = 1'b1; @(negedge clk); clrMatch = 1'b0;
    check("R8", "match cleared", matchFlag, 1'b0);
    writeTx(16'h005B);
    waitRx(); @(negedge clk);
    check("R8", "no match on other word", matchFlag, 1'b0);
    pulseRead();
  endtask

  task automatic testOverrun();
    setCfg(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1);
    writeTx(16'h0012);
    repeat (2) @(negedge clk);
    check("R5", "txEmpty once word loaded", txEmpty, 1'b1);
    writeTx(16'h0034);
    repeat (150) @(negedge clk);
    check("R7", "overrun set", overrun, 1'b1);
    check("R7", "older word kept", rxData, 16'h00ED);
    check("R12", "irq from overrun", irq, 1'b1);
    @(negedge clk); clrOverrun = 1'b1; @(negedge clk); clrOverrun = 1'b0;
    check("R7", "overrun cleared", overrun, 1'b0);
    pulseRead();
  endtask

  task automatic testFault();
    setCfg(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1);
    @(negedge clk); ssIn = 1'b0;
    repeat (4) @(negedge clk);
    check("R9", "modeFault set", modeFault, 1'b1);
    check("R9", "irq on fault", irq, 1'b1);
    check("R9", "drivers released", {sclkOe, mosiOe, ssOe}, 3'b000);
    writeTx(16'h003C);
    repeat (3) @(negedge clk);
    writeTx(16'h0099);
    repeat (20) @(negedge clk);
    check("R9", "queued word held off", txEmpty, 1'b0);
    @(negedge clk); ssIn = 1'b1;
    repeat (4) @(negedge clk);
    check("R10", "fault sticky", modeFault, 1'b1);
    @(negedge clk); clrModeFault = 1'b1; @(negedge clk); clrModeFault = 1'b0;
    check("R10", "fault cleared", modeFault, 1'b0);
    check("R10", "drivers back", {sclkOe, mosiOe, ssOe}, 3'b111);
    waitRx(); @(negedge clk);
    check("R5", "write while full ignored", rxData, 16'h00C3);
    pulseRead();
  endtask

  task automatic slaveXfer(input logic [15:0] txW, input logic [15:0] inW,
                           input bit pol, input bit pha, input bit lsb, input bit wide);
    int n = wide ? 16 : 8;
    int h = 8;
    logic [15:0] got = '0;
    @(negedge clk); sclkIn = pol; ssIn = 1'b1;
    setCfg(1'b0, pol, pha, lsb, wide, 8'd0);
    writeTx(txW);
    @(negedge clk); ssIn = 1'b0;
    repeat (h) @(negedge clk);
    check("R11", "misoOe while selected", misoOe, 1'b1);
    for (int i = 0; i < n; i++) begin
      logic b = lsb ? inW[i] : inW[n-1-i];
      if (!pha) begin
        mosiIn = b;
        repeat (h) @(negedge clk);
        got = {got[14:0], misoOut}; sclkIn = ~pol;
        repeat (h) @(negedge clk);
        sclkIn = pol;
      end else begin
        repeat (h) @(negedge clk);
        sclkIn = ~pol;
        repeat (h / 2) @(negedge clk);
        mosiIn = b;
        repeat (h / 2) @(negedge clk);
        got = {got[14:0], misoOut}; sclkIn = pol;
      end
    end
    repeat (h) @(negedge clk);
    ssIn = 1'b1;
    repeat (6) @(negedge clk);
    check("R11", "misoOe after release", misoOe, 1'b0);
    check("R11", "slave rxFull", rxFull, 1'b1);
    check("R11", "slave received word", rxData, inW & maskOf(wide));
    check("R11", "slave sent bits", got & maskOf(wide), serialOf(txW, lsb, n));
    pulseRead();
  endtask

  initial begin
    rstN = 1'b0; cfgEnable = 1'b0; cfgMaster = 1'b0; cfgCpol = 1'b0; cfgCpha = 1'b0;
    cfgLsbFirst = 1'b0; cfgWide = 1'b0; cfgDiv = 8'd1; matchValue = 16'hFFFF;
    txWrite = 1'b0; txData = '0; rxRead = 1'b0; clrModeFault = 1'b0;
    clrOverrun = 1'b0; clrMatch = 1'b0; sclkIn = 1'b0; mosiIn = 1'b0; ssIn = 1'b1;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    masterXfer(16'h00B1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1);
    masterXfer(16'hA51E, 1'b0, 1'b1, 1'b1, 1'b1, 8'd2);
    masterXfer(16'h6C03, 1'b1, 1'b0, 1'b0, 1'b1, 8'd0);
    masterXfer(16'hFF4D, 1'b1, 1'b1, 1'b1, 1'b0, 8'd3);
    testMatch();
    testOverrun();
    testFault();
    slaveXfer(16'h0096, 16'h0035, 1'b0, 1'b0, 1'b0, 1'b0);
    slaveXfer(16'hC3A1, 16'h5E27, 1'b1, 1'b1, 1'b1, 1'b1);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule